// File: doc/BRIEF.md
# Dataflow Thread Frame Scheduler

This block keeps track of threads in a decoupled dataflow processor. Each thread owns one fixed-size activation frame, so the block deals only in frame indices. A pipeline asks for a new thread with an allocate request that carries the number of inputs the thread must wait for. The free indices sit in a last-in-first-out stack, and the allocation is answered in the same cycle with the index on top of that stack. Each store into a frame counts down that frame's input count. A frame whose count reaches zero joins a ready queue. The thread at the head of the queue is handed to an execution pipeline together with a register set. Register sets come from a circular pool and are given out in first-in-first-out order. When the thread ends, a free request puts its frame index back on the stack and its register set back into the pool.

Each frame runs its own small state machine with four states: `F_FREE`, `F_WAIT`, `F_READY` and `F_RUN`. The transitions are:
- FREE to WAIT: allocated with a nonzero count.
- FREE to READY: allocated with a count of zero.
- WAIT to READY: a store brings the count from one to zero.
- READY to RUN: the frame is dispatched with a register set.
- RUN to FREE: a free request for the frame.

Any store or free that does not match one of these transitions is ignored and raises a sticky error flag.

Top module: `dtf_sched`

## Requirements
- R1: After reset every frame is free and the error flag is low. No dispatch is offered. `alloc_ok` is high and `alloc_fidx` shows NFRAMES-1. Successive allocations then return descending indices.
- R2: `alloc_ok` and `alloc_fidx` show, combinationally, whether an allocation would succeed and the index it would get. An allocate request that succeeds removes that index from the top of the stack at the clock edge.
- R3: An allocate request while no index is free leaves `alloc_ok` low and changes nothing. In particular, a failed request with a count of zero queues no thread.
- R4: A store decrements the count of a waiting frame. The frame becomes ready only on the store that takes its count from 1 to 0. A frame allocated with a count of 0 is ready at once.
- R5: Ready threads are dispatched in the order they became ready. When two threads become ready in the same cycle, they are queued in ascending frame-index order.
- R6: A dispatch presents the head frame index together with a register set. After reset the sets are granted in the order 0, 1, ..., NRSETS-1. Released sets are granted again in the order they were released.
- R7: While no register set is free, `disp_valid` stays low and the head thread waits. While `disp_valid` is high and `disp_ready` is low, `disp_fidx` and `disp_rset` hold.
- R8: A free request for a running frame pushes its index back on the stack, so the next allocation returns that index. It also returns the frame's register set to the pool.
- R9: A store to a frame that is not waiting (count already zero, or not allocated) sets `err_flag`, and so does a free request for a frame that is not running. Such a request has no other effect. `err_flag` stays set until reset.
- R10: When an allocation and a free occur in the same cycle, the allocation receives the current top of the stack and the freed index becomes the new top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate a thread frame |
| alloc_cnt | input | CNT_W | Initial input count for the new thread |
| alloc_ok | output | 1 | A free frame index is available |
| alloc_fidx | output | FW | Index that an allocation receives |
| store_req | input | 1 | One input has arrived for a frame |
| store_fidx | input | FW | Frame addressed by the store |
| free_req | input | 1 | Thread finished; release its frame |
| free_fidx | input | FW | Frame to release |
| disp_valid | output | 1 | A ready thread with a register set is offered |
| disp_ready | input | 1 | Execution pipeline accepts the offer |
| disp_fidx | output | FW | Frame index of the offered thread |
| disp_rset | output | RW | Register set granted to the offered thread |
| err_flag | output | 1 | Sticky protocol error |

## Verification
A wrong per-frame state shows up within a single cycle of the next request for that frame. The symptom is a spurious or missing `err_flag` on a store or free, or a thread that never appears at `disp_valid`. A corrupted stack shows up at once on `alloc_fidx`, because the top index is visible combinationally, and the directed sequences compare it after every push and pop. Pool or queue pointer errors appear on the next dispatch as a wrong `disp_rset` or a wrong `disp_fidx` order. They are caught by scenarios that recycle register sets and that make two threads ready in the same cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [1:0] {
        F_FREE  = 2'd0,
        F_WAIT  = 2'd1,
        F_READY = 2'd2,
        F_RUN   = 2'd3
    } frame_st_t;
endpackage

// File: rtl/dts_lifo.sv
module dts_lifo #(
    parameter int W     = 3,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [W-1:0]  push_d,
    output logic [W-1:0]  top_d,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [LW-1:0] sp;
    logic [IW-1:0] top_idx;

    assign top_idx = IW'(sp - LW'(1));
    assign top_d   = mem[top_idx];
    assign empty   = (sp == '0);
    assign level   = sp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= LW'(DEPTH);
            for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i);
        end else begin
            unique case ({pop, push})
                2'b10: sp <= sp - LW'(1);
                2'b01: begin
                    mem[IW'(sp)] <= push_d;
                    sp <= sp + LW'(1);
                end
                2'b11: mem[top_idx] <= push_d;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dts_fifo.sv
module dts_fifo #(
    parameter int W         = 3,
    parameter int DEPTH     = 8,
    parameter bit INIT_FULL = 1'b0,
    localparam int IW       = $clog2(DEPTH),
    localparam int LW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic [W-1:0]  d0,
    input  logic          push1,
    input  logic [W-1:0]  d1,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] rd, wr, wr1;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    assign wr1   = nxt(wr);
    assign head  = mem[rd];
    assign empty = (level == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd    <= '0;
            wr    <= '0;
            level <= INIT_FULL ? LW'(DEPTH) : '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_FULL ? W'(i) : '0;
        end else begin
            if (push0) mem[wr] <= d0;
            if (push1) mem[wr1] <= d1;
            if (push0) wr <= push1 ? nxt(wr1) : wr1;
            if (pop) rd <= nxt(rd);
            level <= level + LW'(push0) + LW'(push1) - LW'(pop);
        end
    end
endmodule

// File: rtl/dts_frames.sv
module dts_frames
    import dts_pkg::*;
#(
    parameter int NF  = 8,
    parameter int CW  = 4,
    parameter int RW  = 2,
    localparam int FW = $clog2(NF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_fire,
    input  logic [FW-1:0] alloc_idx,
    input  logic [CW-1:0] alloc_cnt,
    input  logic          store_ok,
    input  logic [FW-1:0] store_idx,
    input  logic          disp_fire,
    input  logic [FW-1:0] disp_idx,
    input  logic [RW-1:0] disp_rset,
    input  logic          free_ok,
    input  logic [FW-1:0] free_idx,
    output frame_st_t     st_o   [NF],
    output logic [CW-1:0] cnt_o  [NF],
    output logic [RW-1:0] rset_o [NF]
);
    for (genvar i = 0; i < NF; i++) begin : g_fr
        localparam logic [FW-1:0] ME = FW'(i);
        frame_st_t     st_q, st_d;
        logic [CW-1:0] cnt_q, cnt_d;
        logic [RW-1:0] rs_q, rs_d;

        always_comb begin
            st_d  = st_q;
            cnt_d = cnt_q;
            rs_d  = rs_q;
            unique case (st_q)
                F_FREE: if (alloc_fire && alloc_idx == ME) begin
                    cnt_d = alloc_cnt;
                    st_d  = (alloc_cnt == '0) ? F_READY : F_WAIT;
                end
                F_WAIT: if (store_ok && store_idx == ME) begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) st_d = F_READY;
                end
                F_READY: if (disp_fire && disp_idx == ME) begin
                    st_d = F_RUN;
                    rs_d = disp_rset;
                end
                F_RUN: if (free_ok && free_idx == ME) st_d = F_FREE;
                default: st_d = F_FREE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= F_FREE;
                cnt_q <= '0;
                rs_q  <= '0;
            end else begin
                st_q  <= st_d;
                cnt_q <= cnt_d;
                rs_q  <= rs_d;
            end
        end

        assign st_o[i]   = st_q;
        assign cnt_o[i]  = cnt_q;
        assign rset_o[i] = rs_q;
    end
endmodule

// File: rtl/dtf_sched.sv
module dtf_sched
    import dts_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int NRSETS  = 4,
    parameter int CNT_W   = 4,
    localparam int FW     = $clog2(NFRAMES),
    localparam int RW     = $clog2(NRSETS),
    localparam int SLW    = $clog2(NFRAMES + 1),
    localparam int PLW    = $clog2(NRSETS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_cnt,
    output logic             alloc_ok,
    output logic [FW-1:0]    alloc_fidx,
    input  logic             store_req,
    input  logic [FW-1:0]    store_fidx,
    input  logic             free_req,
    input  logic [FW-1:0]    free_fidx,
    output logic             disp_valid,
    input  logic             disp_ready,
    output logic [FW-1:0]    disp_fidx,
    output logic [RW-1:0]    disp_rset,
    output logic             err_flag
);
    frame_st_t        st   [NFRAMES];
    logic [CNT_W-1:0] cnt  [NFRAMES];
    logic [RW-1:0]    rset [NFRAMES];

    logic          stk_empty;
    logic [FW-1:0] stk_top;
    logic [SLW-1:0] stk_level;
    logic          rq_empty, pool_empty;
    logic [FW-1:0] rq_head;
    logic [RW-1:0] pool_head;
    logic [SLW-1:0] rq_level;
    logic [PLW-1:0] pool_level;

    logic alloc_fire, alloc_zero, store_ok, store_zero, free_ok, disp_fire;
    logic rq_push0, rq_push1;
    logic [FW-1:0] rq_d0, rq_d1;
    frame_st_t disp_st;

    assign alloc_ok   = !stk_empty;
    assign alloc_fidx = stk_top;
    assign alloc_fire = alloc_req && !stk_empty;
    assign alloc_zero = alloc_fire && (alloc_cnt == '0);
    assign store_ok   = store_req && (st[store_fidx] == F_WAIT);
    assign store_zero = store_ok && (cnt[store_fidx] == CNT_W'(1));
    assign free_ok    = free_req && (st[free_fidx] == F_RUN);

    assign disp_valid = !rq_empty && !pool_empty;
    assign disp_fidx  = rq_head;
    assign disp_rset  = pool_head;
    assign disp_fire  = disp_valid && disp_ready;
    assign disp_st    = st[rq_head];

    // ordering of simultaneous arrivals: lower index enters first
    always_comb begin
        rq_push0 = 1'b0;
        rq_push1 = 1'b0;
        rq_d0    = alloc_fidx;
        rq_d1    = store_fidx;
        if (alloc_zero && store_zero) begin
            rq_push0 = 1'b1;
            rq_push1 = 1'b1;
            if (store_fidx < alloc_fidx) begin
                rq_d0 = store_fidx;
                rq_d1 = alloc_fidx;
            end
        end else if (alloc_zero) begin
            rq_push0 = 1'b1;
        end else if (store_zero) begin
            rq_push0 = 1'b1;
            rq_d0    = store_fidx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= err_flag || (store_req && !store_ok)
                                         || (free_req && !free_ok);
    end

    dts_lifo #(.W(FW), .DEPTH(NFRAMES)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .pop(alloc_fire), .push(free_ok), .push_d(free_fidx),
        .top_d(stk_top), .empty(stk_empty), .level(stk_level)
    );

    dts_fifo #(.W(FW), .DEPTH(NFRAMES), .INIT_FULL(1'b0)) u_readyq (
        .clk(clk), .rst_n(rst_n),
        .push0(rq_push0), .d0(rq_d0), .push1(rq_push1), .d1(rq_d1),
        .pop(disp_fire), .head(rq_head), .empty(rq_empty), .level(rq_level)
    );

    dts_fifo #(.W(RW), .DEPTH(NRSETS), .INIT_FULL(1'b1)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .push0(free_ok), .d0(rset[free_fidx]), .push1(1'b0), .d1('0),
        .pop(disp_fire), .head(pool_head), .empty(pool_empty), .level(pool_level)
    );

    dts_frames #(.NF(NFRAMES), .CW(CNT_W), .RW(RW)) u_frames (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .alloc_idx(alloc_fidx), .alloc_cnt(alloc_cnt),
        .store_ok(store_ok), .store_idx(store_fidx),
        .disp_fire(disp_fire), .disp_idx(rq_head), .disp_rset(pool_head),
        .free_ok(free_ok), .free_idx(free_fidx),
        .st_o(st), .cnt_o(cnt), .rset_o(rset)
    );
endmodule

// File: rtl/dts_chk.sv
module dts_chk
    import dts_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int NRSETS  = 4,
    parameter int FW      = 3,
    parameter int RW      = 2,
    localparam int SLW    = $clog2(NFRAMES + 1),
    localparam int PLW    = $clog2(NRSETS + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           alloc_req,
    input logic           alloc_ok,
    input logic           free_req,
    input logic           disp_valid,
    input logic           disp_ready,
    input logic [FW-1:0]  disp_fidx,
    input logic [RW-1:0]  disp_rset,
    input logic           err_flag,
    input frame_st_t      disp_st,
    input logic [SLW-1:0] stk_level,
    input logic [SLW-1:0] rq_level,
    input logic [PLW-1:0] pool_level
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R9
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_fidx) && $stable(disp_rset))); // R7
    AST_HEAD_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_st == F_READY)); // R5
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rq_level <= SLW'(NFRAMES)); // R5
    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pool_level <= PLW'(NRSETS)); // R6
    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= SLW'(NFRAMES)); // R2
    AST_FAIL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ok && !free_req) |=> $stable(stk_level)); // R3
endmodule

bind dtf_sched dts_chk #(.NFRAMES(NFRAMES), .NRSETS(NRSETS), .FW(FW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .free_req(free_req), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_fidx(disp_fidx), .disp_rset(disp_rset), .err_flag(err_flag),
    .disp_st(disp_st), .stk_level(stk_level), .rq_level(rq_level),
    .pool_level(pool_level)
);

// File: tb/sim_dtf_sched.sv
module sim_dtf_sched;
    localparam int NF = 8, NR = 4, CW = 4;
    localparam int FW = $clog2(NF), RW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 0, store_req = 0, free_req = 0, disp_ready = 0;
    logic [CW-1:0] alloc_cnt = '0;
    logic [FW-1:0] store_fidx = '0, free_fidx = '0;
    logic alloc_ok, disp_valid, err_flag;
    logic [FW-1:0] alloc_fidx, disp_fidx;
    logic [RW-1:0] disp_rset;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dtf_sched #(.NFRAMES(NF), .NRSETS(NR), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_cnt(alloc_cnt),
        .alloc_ok(alloc_ok), .alloc_fidx(alloc_fidx), .store_req(store_req),
        .store_fidx(store_fidx), .free_req(free_req), .free_fidx(free_fidx),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_fidx(disp_fidx),
        .disp_rset(disp_rset), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        alloc_req = 0; store_req = 0; free_req = 0; disp_ready = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic do_alloc(input int c, input int exp_idx, input string tag);
        alloc_req = 1; alloc_cnt = CW'(c);
        #1;
        chk({tag, " alloc ok"}, int'(alloc_ok), 1);
        chk({tag, " alloc index"}, int'(alloc_fidx), exp_idx);
        tick();
    endtask

    task automatic do_store(input int f);
        store_req = 1; store_fidx = FW'(f);
        tick();
    endtask

    task automatic do_free(input int f);
        free_req = 1; free_fidx = FW'(f);
        tick();
    endtask

    task automatic do_take(input int ef, input int er, input string tag);
        disp_ready = 1;
        #1;
        chk({tag, " dispatch valid"}, int'(disp_valid), 1);
        chk({tag, " dispatch frame"}, int'(disp_fidx), ef);
        chk({tag, " dispatch set"}, int'(disp_rset), er);
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 alloc_ok", int'(alloc_ok), 1);
        chk("R1 top index", int'(alloc_fidx), NF - 1);
        chk("R1 disp_valid", int'(disp_valid), 0);
        chk("R1 err_flag", int'(err_flag), 0);
    endtask

    task automatic t_basic();
        do_reset();
        do_alloc(2, 7, "R1/R2");
        do_alloc(1, 6, "R2");
        do_store(7);
        chk("R4 not ready at count 1", int'(disp_valid), 0);
        do_store(7);
        chk("R4 ready at zero", int'(disp_valid), 1);
        chk("R6 first set", int'(disp_rset), 0);
        tick();
        chk("R7 hold valid", int'(disp_valid), 1);
        chk("R7 hold frame", int'(disp_fidx), 7);
        do_take(7, 0, "R6");
        chk("R6 queue empty after take", int'(disp_valid), 0);
        do_free(7);
        chk("R8 freed index on top", int'(alloc_fidx), 7);
        do_store(6);
        do_take(6, 1, "R6 next set");
    endtask

    task automatic t_order();
        do_reset();
        do_alloc(0, 7, "R4 zero count");
        do_take(7, 0, "R4 immediate");
        do_alloc(1, 6, "R5");
        do_free(7);
        alloc_req = 1; alloc_cnt = '0; store_req = 1; store_fidx = FW'(6);
        #1;
        chk("R5 alloc index", int'(alloc_fidx), 7);
        tick();
        do_take(6, 1, "R5 lower first");
        do_take(7, 2, "R5 higher second");
    endtask

    task automatic t_pool();
        do_reset();
        for (int k = 0; k < 4; k++) do_alloc(0, 7 - k, "R6");
        for (int k = 0; k < 4; k++) do_take(7 - k, k, "R6 order");
        do_alloc(0, 3, "R7");
        tick();
        chk("R7 waits without set", int'(disp_valid), 0);
        do_free(5);
        do_take(3, 2, "R8 released set reused");
        alloc_req = 1; alloc_cnt = CW'(1); free_req = 1; free_fidx = FW'(6);
        #1;
        chk("R10 alloc gets old top", int'(alloc_fidx), 5);
        tick();
        chk("R10 freed becomes top", int'(alloc_fidx), 6);
        do_alloc(1, 6, "R10");
        #1;
        chk("R10 below top", int'(alloc_fidx), 2);
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < NF; k++) do_alloc(1, NF - 1 - k, "R3 fill");
        alloc_req = 1; alloc_cnt = '0;
        #1;
        chk("R3 alloc_ok low", int'(alloc_ok), 0);
        tick();
        chk("R3 nothing queued", int'(disp_valid), 0);
        chk("R3 still empty", int'(alloc_ok), 0);
        chk("R3 no error", int'(err_flag), 0);
        do_store(0);
        do_take(0, 0, "R3");
        do_free(0);
        chk("R3 recovered ok", int'(alloc_ok), 1);
        chk("R3 recovered index", int'(alloc_fidx), 0);
    endtask

    task automatic t_errors();
        do_reset();
        do_store(3);
        chk("R9 store to free frame", int'(err_flag), 1);
        tick(); tick(); tick();
        chk("R9 sticky", int'(err_flag), 1);
        chk("R9 stack untouched", int'(alloc_fidx), 7);
        chk("R9 nothing queued", int'(disp_valid), 0);
        do_reset();
        do_alloc(1, 7, "R9");
        do_store(7);
        chk("R9 legal store no error", int'(err_flag), 0);
        do_store(7);
        chk("R9 store at zero", int'(err_flag), 1);
        chk("R9 queued thread kept", int'(disp_fidx), 7);
        chk("R9 queued valid", int'(disp_valid), 1);
        do_reset();
        do_alloc(1, 7, "R9");
        do_free(7);
        chk("R9 free not running", int'(err_flag), 1);
        chk("R9 index not pushed", int'(alloc_fidx), 6);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_order();
                t_pool();
                t_full();
                t_errors();
            end
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule